// File: doc/BRIEF.md
# Display Controller Register Access Engine

This block is an SPI master that turns single register commands into the framed byte exchanges expected by a small display controller. A command holds an operation, an 8-bit register number and a 16-bit write value. The client presents it on a valid/ready handshake. The engine then drives the serial clock, the data-out line and an active-low chip select, samples the data-in line, and reports completion with a one-cycle done flag and a 16-bit read result.

A write command and a read command each use two frames. The first frame selects the register and the second frame carries or fetches the value. A status command uses one longer frame whose second received byte is junk. Every frame begins with a start byte that holds a fixed 5-bit prefix, the device identity bit, the select bit and the direction bit. An inversion option, chosen per command, complements every byte sent. The serial clock is derived from the system clock so that register traffic never exceeds the controller's register-access rate.

Top module: `disp_spi_reg_eng`

## Requirements
- R1: Out of reset, cs_no is 1, sclk_o is 0, req_ready_o is 1, done_o is 0 and rdata_o is 0.
- R2: A command is taken on a cycle with req_valid_i and req_ready_o both high. All request fields are captured on that cycle. req_ready_o is low from the next cycle until the command completes, and input changes during that time have no effect on the frames sent.
- R3: Every start byte equals 0x70 | DEV_ID<<2 | SEL<<1 | DIR. SEL=0 addresses the index register and SEL=1 addresses register data. DIR=1 is a read and DIR=0 is a write. DEV_ID defaults to 1.
- R4: Operation 2'b00 (write) sends two 3-byte frames: {start(SEL=0,DIR=0), 0x00, register} and then {start(SEL=1,DIR=0), value[15:8], value[7:0]}.
- R5: Operation 2'b01 (read) sends the same index frame as R4 and then {start(SEL=1,DIR=1), 0x00, 0x00}. rdata_o becomes {second received byte, third received byte} of the second frame.
- R6: A status command sends one 4-byte frame {start(SEL=0,DIR=1), 0x00, 0x00, 0x00}. rdata_o becomes {third received byte, fourth received byte}, and the second received byte is discarded.
- R7: Operation 2'b11 behaves exactly like operation 2'b10 (status).
- R8: When req_inv_i is 1 at acceptance, every transmitted byte is bit-inverted. Received bytes are never inverted.
- R9: The link uses SPI mode 0, MSB first. sclk_o is 0 whenever cs_no is 1. mosi_o never changes while sclk_o is high, and data-in is sampled on the rising edge of sclk_o.
- R10: Each half period of sclk_o is ceil(SYS_CLK_HZ / (2*SCLK_MAX_HZ)) system cycles. This is 7 cycles with the defaults, which gives 3.57 MHz, at or below the 4 MHz register limit. The gap from the chip-select fall to the first rising edge is also one half period.
- R11: Each frame has its own chip-select low period. cs_no stays high for at least GAP_PERIODS (default 2) sclk periods between frames and between commands.
- R12: done_o pulses for exactly one cycle, in the cycle where req_ready_o returns high. rdata_o changes only in a done cycle and keeps its value through a write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command present |
| req_ready_o | output | 1 | Engine idle, command can be taken |
| req_op_i | input | 2 | 00 write, 01 read, 1x status |
| req_idx_i | input | 8 | Register number |
| req_wdata_i | input | 16 | Value for a write |
| req_inv_i | input | 1 | Invert transmitted bytes for this command |
| done_o | output | 1 | One-cycle completion flag |
| rdata_o | output | 16 | Result of the last read or status command |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| cs_no | output | 1 | Chip select, active low |
| miso_i | input | 1 | Serial data in |

## Verification
An accepted command drops req_ready_o on the very next cycle. The bench samples req_ready_o one falling clock edge after acceptance and, in a separate case, while the inputs are altered mid-command. Frame contents are collected by a serial device model on each rising sclk_o edge, and the model shifts its reply out on falling edges. The check therefore waits for the done cycle, samples rdata_o and the collected bytes at the falling clock edge of that cycle, and confirms on the following falling edge that done_o has cleared. Edge spacing is measured in time: every sclk_o half period must equal 7 clock periods, including the one after the chip-select fall, and every chip-select high period between frames must be at least 28 clock periods.

// File: rtl/disp_spi_pkg.sv
package disp_spi_pkg;

  localparam int unsigned FRAME_W = 32;
  localparam int unsigned CNT_W   = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP} eng_state_e;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [CNT_W-1:0]   nbits;
  } frame_t;

  function automatic logic [7:0] start_byte(logic id, logic sel, logic dir);
    return {5'b01110, id, sel, dir};
  endfunction

  // op[1]: status; op[0]: read. second selects the data frame.
  function automatic frame_t build_frame(logic [1:0] op, logic second,
                                         logic [7:0] idx, logic [15:0] wd,
                                         logic inv, logic id);
    frame_t f;
    if (op[1]) begin
      f.bits  = {start_byte(id, 1'b0, 1'b1), 24'h0};
      f.nbits = CNT_W'(32);
    end else if (!second) begin
      f.bits  = {start_byte(id, 1'b0, 1'b0), 8'h00, idx, 8'h00};
      f.nbits = CNT_W'(24);
    end else if (op[0]) begin
      f.bits  = {start_byte(id, 1'b1, 1'b1), 24'h0};
      f.nbits = CNT_W'(24);
    end else begin
      f.bits  = {start_byte(id, 1'b1, 1'b0), wd, 8'h00};
      f.nbits = CNT_W'(24);
    end
    f.bits = f.bits ^ {FRAME_W{inv}};
    return f;
  endfunction

endpackage

// File: rtl/disp_spi_tick.sv
module disp_spi_tick #(
  parameter int unsigned HALF = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/disp_spi_shift.sv
module disp_spi_shift
  import disp_spi_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        load_i,
  input  frame_t      frame_i,
  input  logic        miso_i,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic        cs_no,
  output logic [15:0] rx_o,
  output logic        done_o
);
  logic [FRAME_W-1:0] tx_q;
  logic [15:0]        rx_q;
  logic [CNT_W-1:0]   bit_q;
  logic [CNT_W-1:0]   nbits_q;
  logic               act_q;
  logic               sclk_q;
  logic               last_bit;

  assign last_bit = (bit_q == nbits_q - CNT_W'(1));
  assign done_o   = act_q && tick_i && sclk_q && last_bit;
  assign sclk_o   = sclk_q;
  assign mosi_o   = act_q ? tx_q[FRAME_W-1] : 1'b0;
  assign cs_no    = !act_q;
  assign rx_o     = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q    <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      nbits_q <= '0;
      act_q   <= 1'b0;
      sclk_q  <= 1'b0;
    end else if (load_i) begin
      tx_q    <= frame_i.bits;
      nbits_q <= frame_i.nbits;
      bit_q   <= '0;
      act_q   <= 1'b1;
      sclk_q  <= 1'b0;
    end else if (act_q && tick_i) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_q   <= {rx_q[14:0], miso_i};
      end else begin
        sclk_q <= 1'b0;
        tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
        if (last_bit) act_q <= 1'b0;
        else          bit_q <= bit_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/disp_spi_reg_eng.sv
module disp_spi_reg_eng
  import disp_spi_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ  = 50_000_000,
  parameter int unsigned SCLK_MAX_HZ = 4_000_000,
  parameter bit          DEV_ID      = 1'b1,
  parameter int unsigned GAP_PERIODS = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [1:0]  req_op_i,
  input  logic [7:0]  req_idx_i,
  input  logic [15:0] req_wdata_i,
  input  logic        req_inv_i,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic        cs_no,
  input  logic        miso_i
);
  localparam int unsigned HALF      = (SYS_CLK_HZ + 2*SCLK_MAX_HZ - 1) / (2*SCLK_MAX_HZ);
  localparam int unsigned GAP_TICKS = 2 * GAP_PERIODS;
  localparam int unsigned GW        = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;

  eng_state_e    state_q;
  logic [1:0]    op_q;
  logic [7:0]    idx_q;
  logic [15:0]   wd_q;
  logic          inv_q;
  logic          second_q;
  logic [GW-1:0] gap_q;
  logic          done_q;
  logic [15:0]   rdata_q;

  logic          tick;
  logic          accept;
  logic          gap_end;
  logic          more;
  logic          load;
  logic          sh_done;
  logic [15:0]   sh_rx;
  frame_t        frame;

  assign accept  = req_valid_i && (state_q == ST_IDLE);
  assign gap_end = (state_q == ST_GAP) && tick && (gap_q == GW'(GAP_TICKS - 1));
  assign more    = !second_q && !op_q[1];
  assign load    = accept || (gap_end && more);
  assign frame   = accept ? build_frame(req_op_i, 1'b0, req_idx_i, req_wdata_i, req_inv_i, DEV_ID)
                          : build_frame(op_q, 1'b1, idx_q, wd_q, inv_q, DEV_ID);

  disp_spi_tick #(.HALF(HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q != ST_IDLE),
    .tick_o (tick)
  );

  disp_spi_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .load_i  (load),
    .frame_i (frame),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .cs_no   (cs_no),
    .rx_o    (sh_rx),
    .done_o  (sh_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      idx_q    <= '0;
      wd_q     <= '0;
      inv_q    <= 1'b0;
      second_q <= 1'b0;
      gap_q    <= '0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q     <= req_op_i;
          idx_q    <= req_idx_i;
          wd_q     <= req_wdata_i;
          inv_q    <= req_inv_i;
          second_q <= 1'b0;
          state_q  <= ST_FRAME;
        end
        ST_FRAME: if (sh_done) begin
          gap_q   <= '0;
          state_q <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          gap_q <= gap_q + GW'(1);
          if (gap_end) begin
            if (more) begin
              second_q <= 1'b1;
              state_q  <= ST_FRAME;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              if (op_q != 2'b00) rdata_q <= sh_rx;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/disp_spi_reg_eng_chk.sv
module disp_spi_reg_eng_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        done_o,
  input logic [15:0] rdata_o,
  input logic        sclk_o,
  input logic        mosi_o,
  input logic        cs_no
);
  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (cs_no && !sclk_o)); // R11
  AST_SCLK_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R9
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
  AST_DONE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o); // R12
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o); // R12
endmodule

bind disp_spi_reg_eng disp_spi_reg_eng_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .rdata_o     (rdata_o),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .cs_no       (cs_no)
);

// File: tb/tb_disp_spi_reg_eng.sv
`timescale 1ns/1ps
module tb_disp_spi_reg_eng;
  localparam logic ID   = 1'b1;
  localparam time  HALF_NS = 140;
  localparam time  GAP_NS  = 560;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_op_i = '0;
  logic [7:0]  req_idx_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        req_inv_i = 1'b0;
  logic        done_o;
  logic [15:0] rdata_o;
  logic        sclk_o, mosi_o, cs_no;
  logic        miso_i = 1'b0;

  int checks = 0, fails = 0, cycles = 0;
  int r9_viol = 0, r10_viol = 0, r11_viol = 0;
  logic [15:0] exp_rd = '0;

  disp_spi_reg_eng dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_op_i(req_op_i), .req_idx_i(req_idx_i), .req_wdata_i(req_wdata_i),
    .req_inv_i(req_inv_i), .done_o(done_o), .rdata_o(rdata_o), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .cs_no(cs_no), .miso_i(miso_i)
  );

  always #10 clk_i = ~clk_i;

  // serial device model
  logic [7:0]  cap [4][4];
  int          cap_len [4];
  int          nfr = 0, bitc = 0;
  logic [7:0]  cur = '0;
  logic [31:0] slave_resp = '0, slave_sr = '0;
  time         last_edge = 0, last_rise = 0;
  bit          have_rise = 1'b0;

  always @(negedge cs_no) begin
    bitc = 0;
    slave_sr = slave_resp;
    miso_i = slave_sr[31];
    last_edge = $time;
    if (have_rise && ($time - last_rise < GAP_NS)) r11_viol++;
  end
  always @(posedge cs_no) begin
    if (nfr < 4) cap_len[nfr] = bitc / 8;
    nfr++;
    last_rise = $time;
    have_rise = 1'b1;
    miso_i = 1'b0;
  end
  always @(posedge sclk_o) if (!cs_no) begin
    if ($time - last_edge != HALF_NS) r10_viol++;
    last_edge = $time;
    cur = {cur[6:0], mosi_o};
    bitc++;
    if ((bitc % 8 == 0) && nfr < 4 && bitc / 8 <= 4) cap[nfr][bitc/8-1] = cur;
  end
  always @(negedge sclk_o) if (!cs_no) begin
    if ($time - last_edge != HALF_NS) r10_viol++;
    last_edge = $time;
    slave_sr = {slave_sr[30:0], 1'b0};
    miso_i = slave_sr[31];
  end
  always @(mosi_o) begin
    #1;
    if (!cs_no && sclk_o) r9_viol++;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
        summary();
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] stb(logic sel, logic dir);
    return {5'b01110, ID, sel, dir};
  endfunction

  task automatic clear_cap();
    nfr = 0;
    for (int i = 0; i < 4; i++) cap_len[i] = 0;
  endtask

  task automatic drive(input logic [1:0] op, input logic [7:0] idx,
                       input logic [15:0] wd, input logic inv);
    req_op_i = op; req_idx_i = idx; req_wdata_i = wd; req_inv_i = inv;
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] idx,
                      input logic [15:0] wd, input logic inv);
    @(negedge clk_i);
    drive(op, idx, wd, inv);
    req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R2", {31'b0, req_ready_o}, 32'd0);
  endtask

  task automatic wait_done();
    int n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!done_o && n < 5000);
    if (n >= 5000) chk("R12", 32'd0, 32'd1);
  endtask

  // called in the done cycle
  task automatic verify(input logic [1:0] op, input logic [7:0] idx,
                        input logic [15:0] wd, input logic inv, input logic [31:0] resp);
    logic [7:0] e [2][4];
    int elen [2];
    int ef;
    logic [7:0] m;
    string tag, dtag;
    m = inv ? 8'hFF : 8'h00;
    for (int f = 0; f < 2; f++) for (int b = 0; b < 4; b++) e[f][b] = 8'h00;
    if (op[1]) begin
      ef = 1; elen[0] = 4; elen[1] = 0;
      e[0][0] = stb(1'b0, 1'b1);
    end else begin
      ef = 2; elen[0] = 3; elen[1] = 3;
      e[0][0] = stb(1'b0, 1'b0); e[0][2] = idx;
      if (op[0]) e[1][0] = stb(1'b1, 1'b1);
      else begin
        e[1][0] = stb(1'b1, 1'b0); e[1][1] = wd[15:8]; e[1][2] = wd[7:0];
      end
    end
    tag  = (op == 2'b11) ? "R7" : op[1] ? "R6" : op[0] ? "R5" : "R4";
    dtag = inv ? "R8" : tag;
    chk(tag, nfr, ef);
    for (int f = 0; f < ef; f++) begin
      chk((f == 0) ? "R11" : tag, cap_len[f], elen[f]);
      chk("R3", {24'b0, cap[f][0]}, {24'b0, e[f][0] ^ m});
      for (int b = 1; b < elen[f]; b++) chk(dtag, {24'b0, cap[f][b]}, {24'b0, e[f][b] ^ m});
    end
    if (op[1])      exp_rd = resp[15:0];
    else if (op[0]) exp_rd = resp[23:8];
    chk((op == 2'b00) ? "R12" : tag, {16'b0, rdata_o}, {16'b0, exp_rd});
    chk("R12", {31'b0, req_ready_o}, 32'd1);
    clear_cap();
    @(negedge clk_i);
    chk("R12", {31'b0, done_o}, 32'd0);
  endtask

  task automatic run(input logic [1:0] op, input logic [7:0] idx,
                     input logic [15:0] wd, input logic inv, input logic [31:0] resp);
    clear_cap();
    slave_resp = resp;
    send(op, idx, wd, inv);
    wait_done();
    verify(op, idx, wd, inv, resp);
  endtask

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk_i);
    chk("R1", {31'b0, cs_no}, 32'd1);
    chk("R1", {31'b0, sclk_o}, 32'd0);
    chk("R1", {31'b0, req_ready_o}, 32'd1);
    chk("R1", {31'b0, done_o}, 32'd0);
    chk("R1", {16'b0, rdata_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // directed cases
    run(2'b00, 8'h10, 16'h4240, 1'b0, 32'hDEADBEEF);
    run(2'b01, 8'h00, 16'h0000, 1'b0, 32'hA5922100);
    run(2'b10, 8'h00, 16'h0000, 1'b0, 32'h11223344);
    run(2'b00, 8'h56, 16'h080F, 1'b0, 32'hFFFFFFFF);   // rdata held through write (R12)
    run(2'b00, 8'h13, 16'h1319, 1'b1, 32'h0);
    run(2'b01, 8'hFF, 16'hFFFF, 1'b1, 32'h00FFFF00);
    run(2'b11, 8'h22, 16'h1234, 1'b1, 32'h5A5AC3E1);
    run(2'b01, 8'h45, 16'h0000, 1'b0, 32'hFF0000FF);

    // inputs changed and valid held while busy (R2)
    clear_cap();
    slave_resp = 32'h01234567;
    send(2'b00, 8'h21, 16'hABCD, 1'b0);
    repeat (40) @(negedge clk_i);
    drive(2'b01, 8'h7E, 16'h5555, 1'b1);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    chk("R2", {31'b0, req_ready_o}, 32'd0);
    wait_done();
    verify(2'b00, 8'h21, 16'hABCD, 1'b0, 32'h01234567);
    req_valid_i = 1'b0;
    chk("R2", {31'b0, req_ready_o}, 32'd0);
    wait_done();
    verify(2'b01, 8'h7E, 16'h5555, 1'b1, 32'h01234567);

    // constrained random
    for (int i = 0; i < 30; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      run(op, 8'($urandom), 16'($urandom), 1'($urandom), $urandom);
    end

    repeat (40) @(negedge clk_i);
    chk("R9", r9_viol, 0);
    chk("R10", r10_viol, 0);
    chk("R11", r11_viol, 0);
    summary();
    $finish;
  end
endmodule